// File: doc/BRIEF.md
# Fractional Baud Rate Divisor

This block turns a fast reference clock into the oversampling tick that paces a UART, and it also marks the end of each bit time. The divisor has a 16-bit integer part, given as a high byte and a low byte, and a 4-bit fraction counted in sixteenths. The mean tick period is the integer plus the fraction over 16, in reference clocks. The block builds the fraction by making some tick periods one reference clock longer than the integer. It spreads these longer periods as evenly as it can over each run of sixteen periods.

A two-bit sampling select sets how many ticks make one bit time: 16, 8 or 4. A bit strobe comes out together with the tick that ends each bit time. Any change on the divisor fields or on the sampling select restarts the tick counter, the fractional phase and the bit count. Because of this, a reprogrammed divisor never gives a shortened tick period. With a 24 MHz reference and 16x sampling, two example settings are:

- integer 13 with fraction 0 gives about 115200 baud;
- integer 1 with fraction 8/16 gives 1000000 baud.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_ni is low, tick_o and bit_stb_o are low. After reset, no tick comes until a nonzero integer divisor is present.
- R2: The integer divisor D is {div_hi_i, div_lo_i}, with the high byte in bits 15:8. With fraction 0, tick_o pulses once every D clock cycles. For example, D = 3750 is high byte 0x0E and low byte 0xA6.
- R3: With fraction F, any sixteen consecutive tick periods counted from a restart last 16*D + F clock cycles in total.
- R4: Number the tick periods p = 0..15 from a restart, repeating. Period p lasts D+1 cycles when floor((p+1)*F/16) > floor(p*F/16), and D cycles otherwise. Period 0 is the first period after the restart.
- R5: With D = 0, neither tick_o nor bit_stb_o is ever asserted, whatever the fraction.
- R6: osr_sel_i selects N ticks per bit: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 4 and 2'b11 gives 16. bit_stb_o is asserted together with the N-th, 2N-th, 3N-th and later ticks counted from a restart, and never without tick_o.
- R7: Suppose div_hi_i, div_lo_i, div_frac_i or osr_sel_i takes a new value in cycle t. Then tick_o is low in cycle t, and the first tick after the change is in cycle t+D.
- R8: For D >= 2, tick_o is a single-cycle pulse. For D = 1 with fraction 0, tick_o stays high in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_hi_i | input | 8 | High byte of the integer divisor |
| div_lo_i | input | 8 | Low byte of the integer divisor |
| div_frac_i | input | 4 | Fraction of the divisor in sixteenths |
| osr_sel_i | input | 2 | Sampling select: ticks per bit |
| tick_o | output | 1 | Oversample tick |
| bit_stb_o | output | 1 | Strobe on the tick that ends a bit time |

## Verification
The assertions assume the divisor and sampling inputs change only synchronously to clk_i, and they treat every change of value as a restart. The no-double-pulse property also assumes that the integer divisor seen in the tick cycle holds into the next cycle unless it changes, and a change is caught by the restart rule. The bench drives every input 2 ns after a rising edge and samples 5 ns after it. It changes the configuration only through one task, so each restart falls in a known cycle from which the expected tick and strobe cycles are counted.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W  = 8;
  localparam int INT_W   = 2 * BYTE_W;
  localparam int FRAC_W  = 4;
  localparam int OSR_MAX = 16;
  localparam int BC_W    = $clog2(OSR_MAX);

  typedef enum logic [1:0] {
    OSR_X16 = 2'b00,
    OSR_X8  = 2'b01,
    OSR_X4  = 2'b10,
    OSR_RSV = 2'b11
  } osr_e;

  function automatic logic [BC_W:0] osr_ticks(osr_e sel);
    case (sel)
      OSR_X8:  osr_ticks = (BC_W+1)'(OSR_MAX / 2);
      OSR_X4:  osr_ticks = (BC_W+1)'(OSR_MAX / 4);
      default: osr_ticks = (BC_W+1)'(OSR_MAX);
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_watch.sv
module baud_cfg_watch #(
  parameter int CFG_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             restart_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  // any new value (a register write upstream) restarts the pacing
  assign restart_o = (cfg_i != cfg_q);
endmodule

// File: rtl/baud_frac_sched.sv
module baud_frac_sched #(
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              stretch_o
);
  localparam int PW = 2 * FRAC_W + 1;

  logic [FRAC_W-1:0] phase_q;
  logic [PW-1:0]     prod_now, prod_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (!run_i) phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + 1'b1;
  end

  // a period is long when floor(p*F/2^FRAC_W) steps at p+1
  assign prod_now  = PW'(phase_q) * PW'(frac_i);
  assign prod_nxt  = (PW'(phase_q) + PW'(1)) * PW'(frac_i);
  assign stretch_o = (prod_nxt >> FRAC_W) != (prod_now >> FRAC_W);
endmodule

// File: rtl/baud_tick_cnt.sv
module baud_tick_cnt #(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [INT_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             tick_o
);
  localparam int LW = INT_W + 1;

  logic [INT_W-1:0] cnt_q;
  logic [LW-1:0]    period_len;

  assign period_len = LW'(div_i) + LW'(stretch_i);
  assign tick_o     = run_i && (LW'(cnt_q) == period_len - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_bit_cnt.sv
module baud_bit_cnt
  import baud_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] osr_i,
  output logic       bit_stb_o
);
  logic [BC_W-1:0] bcnt_q;
  logic [BC_W:0]   n_ticks;

  assign n_ticks   = osr_ticks(osr_e'(osr_i));
  assign bit_stb_o = tick_i && ({1'b0, bcnt_q} == n_ticks - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bcnt_q <= '0;
    else if (!run_i)    bcnt_q <= '0;
    else if (bit_stb_o) bcnt_q <= '0;
    else if (tick_i)    bcnt_q <= bcnt_q + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic [1:0]        osr_sel_i,
  output logic              tick_o,
  output logic              bit_stb_o
);
  localparam int CFG_W = INT_W + FRAC_W + 2;

  logic [INT_W-1:0] div_int;
  logic             restart, run, stretch, tick;

  assign div_int = {div_hi_i, div_lo_i};

  baud_cfg_watch #(.CFG_W(CFG_W)) u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     ({div_int, div_frac_i, osr_sel_i}),
    .restart_o (restart)
  );

  // zero integer stops everything, fraction ignored
  assign run = (div_int != '0) && !restart;

  baud_frac_sched #(.FRAC_W(FRAC_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .frac_i    (div_frac_i),
    .stretch_o (stretch)
  );

  baud_tick_cnt #(.INT_W(INT_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .div_i     (div_int),
    .stretch_i (stretch),
    .tick_o    (tick)
  );

  baud_bit_cnt u_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .osr_i     (osr_sel_i),
    .bit_stb_o (bit_stb_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] div_hi_i,
  input logic [7:0] div_lo_i,
  input logic [3:0] div_frac_i,
  input logic [1:0] osr_sel_i,
  input logic       tick_o,
  input logic       bit_stb_o
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!tick_o && !bit_stb_o));

  assert_zero_div_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({div_hi_i, div_lo_i} == 16'd0) |-> (!tick_o && !bit_stb_o));

  assert_strobe_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> tick_o);

  assert_no_tick_on_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({div_hi_i, div_lo_i, div_frac_i, osr_sel_i}) |-> !tick_o);

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ({div_hi_i, div_lo_i} >= 16'd2)) |=> !tick_o);
endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_hi_i   (div_hi_i),
  .div_lo_i   (div_lo_i),
  .div_frac_i (div_frac_i),
  .osr_sel_i  (osr_sel_i),
  .tick_o     (tick_o),
  .bit_stb_o  (bit_stb_o)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hi = '0, lo = '0;
  logic [3:0] fr = '0;
  logic [1:0] osr = '0;
  logic       tick, stb;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_hi_i(hi), .div_lo_i(lo),
    .div_frac_i(fr), .osr_sel_i(osr), .tick_o(tick), .bit_stb_o(stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int long_p(input int p, input int f);
    return (((p + 1) * f) / 16 > (p * f) / 16) ? 1 : 0;
  endfunction

  function automatic int n_of(input logic [1:0] s);
    return (s == 2'b01) ? 8 : (s == 2'b10) ? 4 : 16;
  endfunction

  task automatic set_cfg(input int d, input int f, input logic [1:0] s, input bit quiet_chk);
    @(posedge clk); #2;
    hi = 8'(d >> 8); lo = 8'(d); fr = 4'(f); osr = s;
    #3;
    if (quiet_chk) check(tick == 1'b0, "R7 no tick in change cycle", int'(tick), 0);
  endtask

  // sample cycles after a restart; tick j expected at sum of period lengths
  task automatic run_pattern(input int d, input int f, input logic [1:0] s,
                             input int nticks, input string tag);
    int k = 0, j = 0, exp_k, n, sum16 = 0, err = 0;
    set_cfg(d, f, s, 1'b1);
    n = n_of(s);
    exp_k = d + long_p(0, f) - 1;
    while (j < nticks && err == 0) begin
      @(posedge clk); #5;
      if (stb && !tick) begin
        err++; check(1'b0, {tag, " R6 strobe without tick"}, k, -1);
      end
      if (tick) begin
        if (k != exp_k) begin
          err++; check(1'b0, {tag, " tick cycle"}, k, exp_k);
        end
        else begin
          check(int'(stb) == int'((j % n) == n - 1), {tag, " R6 strobe"}, int'(stb),
                int'((j % n) == n - 1));
          if (j < 16) sum16 += d + long_p(j, f);
        end
        j++;
        exp_k = k + d + long_p(j % 16, f);
      end
      else if (k >= exp_k) begin
        err++; check(1'b0, {tag, " missing tick"}, k, exp_k);
      end
      k++;
    end
    if (err == 0 && nticks >= 16)
      check(sum16 == 16 * d + f, {tag, " R3 16-period sum"}, sum16, 16 * d + f);
  endtask

  task automatic t_reset;
    #5;
    check(tick == 0 && stb == 0, "R1 outputs low in reset", int'(tick), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (20) begin
      @(posedge clk); #5;
      check(tick == 0, "R1 no tick without divisor", int'(tick), 0);
    end
  endtask

  task automatic t_zero(input int f);
    int cnt = 0;
    set_cfg(0, f, 2'b00, 1'b0);
    repeat (100) begin
      @(posedge clk); #5;
      cnt += int'(tick) + int'(stb);
    end
    check(cnt == 0, "R5 zero divisor silent", cnt, 0);
  endtask

  task automatic t_restart;
    set_cfg(20, 0, 2'b00, 1'b0);
    repeat (25) @(posedge clk);
    run_pattern(7, 0, 2'b00, 3, "R7 restart mid-period");
  endtask

  task automatic t_osr_restart;
    run_pattern(2, 0, 2'b00, 10, "R6 pre");
    run_pattern(2, 0, 2'b01, 16, "R7 osr-only restart");
  endtask

  task automatic t_reset_mid;
    set_cfg(1, 0, 2'b00, 1'b0);
    repeat (5) @(posedge clk);
    #2; rst_n = 1'b0; #3;
    check(tick == 0 && stb == 0, "R1 reset mid-run", int'(tick), 0);
    @(posedge clk); #2; rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    run_pattern(13, 0, 2'b00, 40, "R2 div13");
    run_pattern(1, 0, 2'b00, 20, "R8 div1 continuous");
    run_pattern(1, 8, 2'b00, 34, "R4 div1.5");
    run_pattern(6, 11, 2'b01, 33, "R4 div6+11/16 x8");
    run_pattern(2, 0, 2'b10, 16, "R6 x4");
    run_pattern(3, 15, 2'b11, 32, "R6 reserved sel x16");
    run_pattern(3750, 0, 2'b00, 2, "R2 div3750");
    t_zero(5);
    t_zero(0);
    t_restart();
    t_osr_restart();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule